// File: doc/BRIEF.md
# Buffer placement rule checker

A command-processing front end hands this block one descriptor per command. The descriptor lists the address ranges that the command touches: up to two queue segments, the location of the command entry, a set of pointer-list segments, several data ranges and one metadata range. Each range has its own valid strobe. The block compares every valid range against the on-controller buffer window. It then applies the usage flags and the mixing rules to the resulting placements. One cycle after the descriptor, it reports a verdict.

The verdict contains three things: a per-slot hit vector, an abort flag with the status value for invalid buffer use, and a 3-bit code that names the first rule that failed. Each mixing rule has its own capability bit, and setting that bit relaxes the rule. When memory space is disabled, the window is treated as absent and every command passes. The block only classifies; it moves no data and walks no lists.

Slot layout of the descriptor:

| Slot | Contents |
|------|----------|
| 0 | Queue segment A |
| 1 | Queue segment B |
| 2 | Command entry |
| 3 .. 3+NL-1 | List segments |
| next ND | Data ranges |
| last | Metadata range |

Range i occupies `rng_start[i*AW +: AW]` and `rng_len[i*LW +: LW]`. A range covers bytes start through start+len-1. A length of zero is treated as one byte.

Top module: `bufwin_rule_check`

## Requirements
- R1: A valid range sets its `res_hit` bit when two conditions hold: `space_en` is 1, and its start address S satisfies win_base <= S < win_base + win_size. The hit depends on the start address only. Invalid slots never hit.
- R2: When `space_en` is 0, every range misses and the verdict is a pass, whatever the flags and ranges are.
- R3: A range is "in the buffer" if any of its bytes falls inside the window. Any such range whose usage flag is 0 fails with code 1. The `use_flags` bits are: 0 submission queue, 1 completion queue, 2 lists, 3 read data, 4 write data.
  - Queue segments use bit 0 when `desc_qsq` is 1 and bit 1 otherwise.
  - The command entry uses bit 0.
  - List segments use bit 2.
  - Data and metadata use bit 3 when `desc_rd` is 1 and bit 4 otherwise.
- R4: The queue-mix rule applies when `cap_flags[0]` is 0. It fails with code 2 if either of two conditions holds:
  - a valid queue segment lies partly inside the window;
  - one valid segment is fully inside while another valid segment is fully outside.
- R5: The contiguity rule applies when `cap_flags[1]` is 0. It fails with code 3 when all of the following hold:
  - both queue segments are valid;
  - either segment is in the buffer;
  - segment B does not start at the address A.start + A.len.
- R6: The list-mix rule applies when `cap_flags[2]` is 0. Under the same partial or mixed test as R4, applied to the list segments, it fails with code 4.
- R7: The independent-list rule applies when `cap_flags[3]` is 0. It fails with code 5 when any list segment is in the buffer and the command entry is not fully inside the window.
- R8: The data-mix rule applies when `cap_flags[4]` is 0. Under the same partial or mixed test as R4, applied to the data and metadata ranges, it fails with code 6.
- R9: If several rules fail, the lowest code is reported.
  - On a failure, `res_abort` is 1 and `res_status` equals the STATUS parameter (default 8'h29).
  - On a pass, `res_code`, `res_abort` and `res_status` are all 0.
- R10: `res_valid` is 1 exactly one cycle after each cycle with `desc_valid` high, and 0 otherwise.
  - The verdict fields change only on a descriptor.
  - All outputs are 0 during reset.
- R11: A range whose start is inside the window but whose end is outside counts as spanning both memories. Likewise, a range that starts below the window and ends inside it counts as in the buffer for R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_base | input | AW | First byte address of the buffer window |
| win_size | input | AW | Window size in bytes |
| space_en | input | 1 | Memory space enable; 0 disables all buffer matching |
| use_flags | input | 5 | Permitted uses of the buffer, encoded as in R3 |
| cap_flags | input | 5 | Relaxation bits: 0 queue mix, 1 discontiguous queue, 2 list mix, 3 independent list, 4 data mix |
| desc_valid | input | 1 | Descriptor strobe |
| desc_qsq | input | 1 | 1: the queue is a submission queue; 0: a completion queue |
| desc_rd | input | 1 | 1: data moves controller to host; 0: host to controller |
| rng_start | input | NR*AW | Start addresses, one per slot |
| rng_len | input | NR*LW | Byte lengths, one per slot |
| rng_vld | input | NR | Per-slot valid strobes |
| res_valid | output | 1 | Verdict strobe |
| res_hit | output | NR | Per-slot window hit |
| res_abort | output | 1 | Command must be aborted |
| res_code | output | 3 | First failing rule, 0 meaning pass |
| res_status | output | 8 | Abort status value, 0 on a pass |

## Verification
The bench builds the block with the following parameters:
- AW = 16 and LW = 12, so every window edge and spanning case uses short, readable addresses;
- NL = 2, so a list can be split between its two segments;
- ND = 1, so the data group holds one data range and the metadata range, which is enough to mix them.

The window is [0x1000, 0x2000), and ranges are placed on its first and last byte and just outside both edges. With six rules on a seven-slot descriptor, each rule can be isolated, relaxed by its bit, and combined with others to expose the priority order.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

   // Rule codes, listed in priority order (lowest nonzero wins)
   typedef enum logic [2:0] {
      RC_PASS  = 3'd0,
      RC_USAGE = 3'd1,
      RC_QMIX  = 3'd2,
      RC_QDISC = 3'd3,
      RC_LMIX  = 3'd4,
      RC_LIND  = 3'd5,
      RC_DMIX  = 3'd6
   } rule_code_e;

   localparam int NUM_RULES = 6;

   // Bit positions in the usage flag vector
   localparam int UF_SQ   = 0;
   localparam int UF_CQ   = 1;
   localparam int UF_LIST = 2;
   localparam int UF_RD   = 3;
   localparam int UF_WR   = 4;

   // Bit positions in the relaxation vector
   localparam int CF_QMIX  = 0;
   localparam int CF_QDISC = 1;
   localparam int CF_LMIX  = 2;
   localparam int CF_LIND  = 3;
   localparam int CF_DMIX  = 4;

   // Fixed descriptor slots
   localparam int SLOT_QA    = 0;
   localparam int SLOT_QB    = 1;
   localparam int SLOT_CMD   = 2;
   localparam int SLOT_LIST0 = 3;

   typedef struct packed {
      logic hit;    // start byte inside the window
      logic touch;  // at least one byte inside the window
      logic full;   // every byte inside the window
   } place_t;

endpackage

// File: rtl/bufwin_range_cls.sv
module bufwin_range_cls
   import bufwin_pkg::*;
#(
   parameter int AW = 48,
   parameter int LW = 32
) (
   input  logic [AW-1:0] win_base,
   input  logic [AW-1:0] win_size,
   input  logic          space_en,
   input  logic [AW-1:0] r_start,
   input  logic [LW-1:0] r_len,
   input  logic          r_vld,
   output place_t        r_pl
);

   localparam int XW   = AW + 1;
   localparam int PADW = XW - LW;

   if (LW > AW) begin : g_bad_lw
      $error("bufwin_range_cls: LW must not exceed AW");
   end

   // One extra bit keeps base+size and start+len free of wrap-around
   logic [XW-1:0] w_lo;
   logic [XW-1:0] w_hi;
   logic [XW-1:0] s_x;
   logic [XW-1:0] nxt_x;
   logic [XW-1:0] last_x;
   logic          gate;
   logic          start_in;
   logic          last_in;

   always_comb begin
      w_lo     = {1'b0, win_base};
      w_hi     = w_lo + {1'b0, win_size};
      s_x      = {1'b0, r_start};
      nxt_x    = s_x + {{PADW{1'b0}}, r_len};
      last_x   = (r_len == '0) ? s_x : (nxt_x - {{AW{1'b0}}, 1'b1});
      gate     = space_en & r_vld;
      start_in = (s_x >= w_lo) && (s_x < w_hi);
      last_in  = (last_x >= w_lo) && (last_x < w_hi);
      r_pl.hit   = gate & start_in;
      r_pl.touch = gate & (last_x >= w_lo) & (s_x < w_hi);
      r_pl.full  = gate & start_in & last_in;
   end

endmodule

// File: rtl/bufwin_group_mix.sv
module bufwin_group_mix #(
   parameter int N = 2
) (
   input  logic [N-1:0] g_vld,
   input  logic [N-1:0] g_touch,
   input  logic [N-1:0] g_full,
   output logic         g_mixed
);

   if (N < 1) begin : g_bad_n
      $error("bufwin_group_mix: N must be at least 1");
   end

   if (N == 1) begin : g_single
      // A lone range can only mix by straddling an edge
      assign g_mixed = g_vld[0] & g_touch[0] & ~g_full[0];
   end else begin : g_multi
      logic any_span;
      logic any_full;
      logic any_out;
      assign any_span = |(g_touch & ~g_full);
      assign any_full = |g_full;
      assign any_out  = |(g_vld & ~g_touch);
      assign g_mixed  = any_span | (any_full & any_out);
   end

endmodule

// File: rtl/bufwin_rule_prio.sv
module bufwin_rule_prio
   import bufwin_pkg::*;
#(
   parameter int NRULE = NUM_RULES
) (
   input  logic [NRULE:1] fail,
   output rule_code_e     code,
   output logic           abort
);

   if (NRULE < 1 || NRULE > 7) begin : g_bad_nrule
      $error("bufwin_rule_prio: NRULE must fit a 3-bit code");
   end

   // Scan downward so that the lowest failing index is written last
   always_comb begin
      code = RC_PASS;
      for (int k = NRULE; k >= 1; k--) begin
         if (fail[k]) code = rule_code_e'(k[2:0]);
      end
   end

   assign abort = |fail;

endmodule

// File: rtl/bufwin_rule_check.sv
module bufwin_rule_check
   import bufwin_pkg::*;
#(
   parameter int          AW     = 48,
   parameter int          LW     = 32,
   parameter int          NL     = 4,
   parameter int          ND     = 4,
   parameter logic [7:0]  STATUS = 8'h29,
   localparam int         NR     = SLOT_LIST0 + NL + ND + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    win_base,
   input  logic [AW-1:0]    win_size,
   input  logic             space_en,
   input  logic [4:0]       use_flags,
   input  logic [4:0]       cap_flags,
   input  logic             desc_valid,
   input  logic             desc_qsq,
   input  logic             desc_rd,
   input  logic [NR*AW-1:0] rng_start,
   input  logic [NR*LW-1:0] rng_len,
   input  logic [NR-1:0]    rng_vld,
   output logic             res_valid,
   output logic [NR-1:0]    res_hit,
   output logic             res_abort,
   output logic [2:0]       res_code,
   output logic [7:0]       res_status
);

   localparam int DATA0 = SLOT_LIST0 + NL;
   localparam int META  = DATA0 + ND;
   localparam int NDM   = ND + 1;
   localparam int XW    = AW + 1;

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("bufwin_rule_check: AW out of range");
   end
   if (LW < 1 || LW > AW) begin : g_bad_lw
      $error("bufwin_rule_check: LW out of range");
   end
   if (NL < 1) begin : g_bad_nl
      $error("bufwin_rule_check: NL must be at least 1");
   end
   if (ND < 1) begin : g_bad_nd
      $error("bufwin_rule_check: ND must be at least 1");
   end

   // ---------------------------------------------------------------
   // Per-slot window classification and usage permission
   // ---------------------------------------------------------------
   place_t        pl [NR];
   logic [NR-1:0] hit;
   logic [NR-1:0] touch;
   logic [NR-1:0] full;
   logic [NR-1:0] allow;
   logic          q_allow;
   logic          d_allow;

   assign q_allow = desc_qsq ? use_flags[UF_SQ] : use_flags[UF_CQ];
   assign d_allow = desc_rd  ? use_flags[UF_RD] : use_flags[UF_WR];

   for (genvar gi = 0; gi < NR; gi++) begin : g_slot
      bufwin_range_cls #(
         .AW (AW),
         .LW (LW)
      ) u_cls (
         .win_base (win_base),
         .win_size (win_size),
         .space_en (space_en),
         .r_start  (rng_start[gi*AW +: AW]),
         .r_len    (rng_len[gi*LW +: LW]),
         .r_vld    (rng_vld[gi]),
         .r_pl     (pl[gi])
      );
      assign hit[gi]   = pl[gi].hit;
      assign touch[gi] = pl[gi].touch;
      assign full[gi]  = pl[gi].full;

      if (gi <= SLOT_QB) begin : g_use_q
         assign allow[gi] = q_allow;
      end else if (gi == SLOT_CMD) begin : g_use_cmd
         assign allow[gi] = use_flags[UF_SQ];
      end else if (gi < DATA0) begin : g_use_list
         assign allow[gi] = use_flags[UF_LIST];
      end else begin : g_use_data
         assign allow[gi] = d_allow;
      end
   end

   // ---------------------------------------------------------------
   // Mixing detection per group
   // ---------------------------------------------------------------
   logic q_mixed;
   logic l_mixed;
   logic d_mixed;

   bufwin_group_mix #(.N(2)) u_mix_q (
      .g_vld   (rng_vld[SLOT_QB:SLOT_QA]),
      .g_touch (touch[SLOT_QB:SLOT_QA]),
      .g_full  (full[SLOT_QB:SLOT_QA]),
      .g_mixed (q_mixed)
   );

   bufwin_group_mix #(.N(NL)) u_mix_l (
      .g_vld   (rng_vld[DATA0-1:SLOT_LIST0]),
      .g_touch (touch[DATA0-1:SLOT_LIST0]),
      .g_full  (full[DATA0-1:SLOT_LIST0]),
      .g_mixed (l_mixed)
   );

   bufwin_group_mix #(.N(NDM)) u_mix_d (
      .g_vld   (rng_vld[META:DATA0]),
      .g_touch (touch[META:DATA0]),
      .g_full  (full[META:DATA0]),
      .g_mixed (d_mixed)
   );

   // Segment B must begin where segment A stops
   logic [XW-1:0] qa_end;
   logic          q_gap;
   logic          q_in_buf;
   logic          l_in_buf;

   assign qa_end   = {1'b0, rng_start[SLOT_QA*AW +: AW]}
                   + {{(XW-LW){1'b0}}, rng_len[SLOT_QA*LW +: LW]};
   assign q_gap    = rng_vld[SLOT_QA] & rng_vld[SLOT_QB]
                   & ({1'b0, rng_start[SLOT_QB*AW +: AW]} != qa_end);
   assign q_in_buf = touch[SLOT_QA] | touch[SLOT_QB];
   assign l_in_buf = |touch[DATA0-1:SLOT_LIST0];

   // ---------------------------------------------------------------
   // Rule evaluation and priority
   // ---------------------------------------------------------------
   logic [NUM_RULES:1] fail;
   rule_code_e         code;
   logic               abort;

   always_comb begin
      fail = '0;
      fail[int'(RC_USAGE)] = |(touch & ~allow);
      fail[int'(RC_QMIX)]  = ~cap_flags[CF_QMIX]  & q_mixed;
      fail[int'(RC_QDISC)] = ~cap_flags[CF_QDISC] & q_in_buf & q_gap;
      fail[int'(RC_LMIX)]  = ~cap_flags[CF_LMIX]  & l_mixed;
      fail[int'(RC_LIND)]  = ~cap_flags[CF_LIND]  & l_in_buf & ~full[SLOT_CMD];
      fail[int'(RC_DMIX)]  = ~cap_flags[CF_DMIX]  & d_mixed;
   end

   bufwin_rule_prio #(.NRULE(NUM_RULES)) u_prio (
      .fail  (fail),
      .code  (code),
      .abort (abort)
   );

   // ---------------------------------------------------------------
   // Verdict register
   // ---------------------------------------------------------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= '0;
         res_abort  <= 1'b0;
         res_code   <= 3'd0;
         res_status <= 8'h00;
      end else begin
         res_valid <= desc_valid;
         if (desc_valid) begin
            res_hit    <= hit;
            res_abort  <= abort;
            res_code   <= code;
            res_status <= abort ? STATUS : 8'h00;
         end
      end
   end

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   AST_VERDICT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |=> res_valid); // R10

   AST_NO_SPURIOUS_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !desc_valid |=> !res_valid); // R10

   AST_DISABLED_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !space_en) |=> (res_hit == '0 && !res_abort)); // R2

   AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |=> ((res_hit & ~$past(rng_vld)) == '0)); // R1

   AST_ABORT_CODE_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_abort == (res_code != 3'd0))); // R9

endmodule

// File: tb/bufwin_rule_check_bench.sv
module bufwin_rule_check_bench;

   localparam int AW = 16;
   localparam int LW = 12;
   localparam int NL = 2;
   localparam int ND = 1;
   localparam int NR = 3 + NL + ND + 1;
   localparam logic [7:0] ST_ABORT = 8'h29;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [AW-1:0]    win_base = 16'h1000;
   logic [AW-1:0]    win_size = 16'h1000;
   logic             space_en;
   logic [4:0]       use_flags;
   logic [4:0]       cap_flags;
   logic             desc_valid = 1'b0;
   logic             desc_qsq;
   logic             desc_rd;
   logic [NR*AW-1:0] rng_start;
   logic [NR*LW-1:0] rng_len;
   logic [NR-1:0]    rng_vld;
   logic             res_valid;
   logic [NR-1:0]    res_hit;
   logic             res_abort;
   logic [2:0]       res_code;
   logic [7:0]       res_status;

   logic [AW-1:0] st [NR];
   logic [LW-1:0] ln [NR];
   logic [NR-1:0] vl;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         rng_start[i*AW +: AW] = st[i];
         rng_len[i*LW +: LW]   = ln[i];
      end
      rng_vld = vl;
   end

   bufwin_rule_check #(
      .AW(AW), .LW(LW), .NL(NL), .ND(ND), .STATUS(ST_ABORT)
   ) u_bufwin_rule_check (
      .clk(clk), .rst_n(rst_n), .win_base(win_base), .win_size(win_size),
      .space_en(space_en), .use_flags(use_flags), .cap_flags(cap_flags),
      .desc_valid(desc_valid), .desc_qsq(desc_qsq), .desc_rd(desc_rd),
      .rng_start(rng_start), .rng_len(rng_len), .rng_vld(rng_vld),
      .res_valid(res_valid), .res_hit(res_hit), .res_abort(res_abort),
      .res_code(res_code), .res_status(res_status)
   );

   typedef struct {
      logic [NR-1:0] hit;
      logic [2:0]    code;
      string         req;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   task automatic clr();
      for (int i = 0; i < NR; i++) begin
         st[i] = '0;
         ln[i] = '0;
      end
      vl        = '0;
      space_en  = 1'b1;
      use_flags = 5'h1F;
      cap_flags = 5'h1F;
      desc_qsq  = 1'b1;
      desc_rd   = 1'b1;
   endtask

   task automatic setr(input int i, input logic [AW-1:0] a, input logic [LW-1:0] l);
      st[i] = a;
      ln[i] = l;
      vl[i] = 1'b1;
   endtask

   // Driver: strobe one descriptor and queue its expected verdict
   task automatic send(input logic [NR-1:0] eh, input logic [2:0] ec, input string req);
      exp_t e;
      @(negedge clk);
      desc_valid = 1'b1;
      e.hit  = eh;
      e.code = ec;
      e.req  = req;
      q.push_back(e);
      @(negedge clk);
      desc_valid = 1'b0;
   endtask

   // Monitor: compare each verdict against the front of the queue
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R10", "verdict without descriptor", 32'(res_valid), 32'd0);
         end else begin
            exp_t e;
            logic       ea;
            logic [7:0] es;
            e  = q.pop_front();
            ea = (e.code != 3'd0);
            es = ea ? ST_ABORT : 8'h00;
            chk(res_hit == e.hit, e.req, "hit vector", 32'(res_hit), 32'(e.hit));
            chk({res_abort, res_status, res_code} == {ea, es, e.code}, e.req,
                "abort/status/code", 32'({res_abort, res_status, res_code}),
                32'({ea, es, e.code}));
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      chk(1'b0, "R10", "watchdog expired", 32'd0, 32'd1);
      report();
   end

   initial begin
      clr();
      #12;
      chk({res_valid, res_abort, res_code, res_status, res_hit} == '0, "R10",
          "reset state", 32'({res_valid, res_abort, res_code, res_status}), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: queue and command at the window base
      clr(); setr(0, 16'h1000, 12'h040); setr(2, 16'h1000, 12'h040);
      send(7'b0000101, 3'd0, "R1");

      // R1: edges of the window (one below, last byte, one above)
      clr(); setr(5, 16'h0FFF, 12'h001); setr(6, 16'h1FFF, 12'h001); setr(3, 16'h2000, 12'h001);
      send(7'b1000000, 3'd0, "R1");
      // R8: same placement with data mixing forbidden
      cap_flags[4] = 1'b0;
      send(7'b1000000, 3'd6, "R8");

      // R11: data range straddling the upper edge
      clr(); setr(5, 16'h1FF0, 12'h020); cap_flags[4] = 1'b0;
      send(7'b0100000, 3'd6, "R11");
      cap_flags[4] = 1'b1;
      send(7'b0100000, 3'd0, "R11");

      // R2: disabled memory space passes everything
      clr(); setr(0, 16'h1000, 12'h100); setr(1, 16'h3000, 12'h100);
      setr(3, 16'h1100, 12'h010); setr(4, 16'h4000, 12'h010); setr(5, 16'h1FF0, 12'h020);
      use_flags = 5'h00; cap_flags = 5'h00; space_en = 1'b0;
      send(7'b0000000, 3'd0, "R2");

      // R3: list in buffer with list use disallowed
      clr(); setr(2, 16'h1000, 12'h040); setr(3, 16'h1100, 12'h010); use_flags = 5'b11011;
      send(7'b0001100, 3'd1, "R3");
      // R3: completion queue in buffer without completion use
      clr(); setr(0, 16'h1000, 12'h040); desc_qsq = 1'b0; use_flags = 5'b11101;
      send(7'b0000001, 3'd1, "R3");
      desc_qsq = 1'b1;
      send(7'b0000001, 3'd0, "R3");
      // R3: host-to-controller data with write use disallowed
      clr(); setr(5, 16'h1200, 12'h010); desc_rd = 1'b0; use_flags = 5'b01111;
      send(7'b0100000, 3'd1, "R3");
      // R11: range starting below the window touches it for usage purposes
      clr(); setr(5, 16'h0FF0, 12'h020); use_flags = 5'b10111;
      send(7'b0000000, 3'd1, "R11");

      // R4: queue split between buffer and host
      clr(); setr(0, 16'h1000, 12'h100); setr(1, 16'h3000, 12'h100); cap_flags[0] = 1'b0;
      send(7'b0000001, 3'd2, "R4");
      // R5: mix allowed, but the segments are not adjacent
      cap_flags[0] = 1'b1; cap_flags[1] = 1'b0;
      send(7'b0000001, 3'd3, "R5");
      cap_flags[1] = 1'b1;
      send(7'b0000001, 3'd0, "R4");

      // R5: adjacent segments pass, a gap fails
      clr(); setr(0, 16'h1000, 12'h100); setr(1, 16'h1100, 12'h100); cap_flags[1] = 1'b0;
      send(7'b0000011, 3'd0, "R5");
      st[1] = 16'h1200;
      send(7'b0000011, 3'd3, "R5");

      // R6: list split between buffer and host
      clr(); setr(2, 16'h1000, 12'h040); setr(3, 16'h1100, 12'h010); setr(4, 16'h4000, 12'h010);
      cap_flags[2] = 1'b0;
      send(7'b0001100, 3'd4, "R6");

      // R7: list in buffer, command in host memory
      clr(); setr(2, 16'h5000, 12'h040); setr(3, 16'h1100, 12'h010); cap_flags[3] = 1'b0;
      send(7'b0001000, 3'd5, "R7");
      st[2] = 16'h1000;
      send(7'b0001100, 3'd0, "R7");

      // R9: usage and list mix together, usage wins
      clr(); setr(2, 16'h1000, 12'h040); setr(3, 16'h1100, 12'h010); setr(4, 16'h4000, 12'h010);
      use_flags = 5'b11011; cap_flags = 5'h00;
      send(7'b0001100, 3'd1, "R9");
      // R9: queue mix, gap and data mix together, queue mix wins
      clr(); setr(0, 16'h1000, 12'h100); setr(1, 16'h3000, 12'h100); setr(5, 16'h1FF0, 12'h020);
      cap_flags = 5'h00;
      send(7'b0100001, 3'd2, "R9");

      // R10: no further verdicts once descriptors stop
      repeat (3) @(negedge clk);
      #1;
      chk(res_valid == 1'b0, "R10", "idle res_valid", 32'(res_valid), 32'd0);
      chk(q.size() == 0, "R10", "pending verdicts", 32'(q.size()), 32'd0);
      report();
   end

endmodule